// File: doc/BRIEF.md
# Synchronous Serial Absolute-Position Slave

This block is the slave side of a synchronous serial position link. An external master drives a clock line; the slave answers with a 24-bit word on a single data line, most significant bit first. The master reads the word with 24 clock cycles. It then gives one more clock pulse to mark the end of the transfer and leaves the clock idle high. The slave has no chip select. It finds the end of a frame by timing how long the clock line has been quiet, using a monoflop measured in system clock cycles. When that timer expires, the shifter resets, so every frame starts aligned at the top bit. This holds whether the frame completed or the master broke off partway.

A host writes the word to be sent through a parallel load port. A write made while no frame is active takes effect at once. A write made during a frame is held back and applied when the monoflop expires, so a frame in progress is never corrupted. The system clock runs several times faster than the serial clock. The serial clock input passes through a two-flop synchronizer and an edge detector before any logic uses it.

Top module: `ssi_slave`

## Requirements
- R1: After reset the data output is 1 and the load word is 0, so a frame read before any host write returns 0x000000.
- R2: While no frame is active the data output is 1.
- R3: In idle, the first falling edge of the serial clock starts a frame and latches the load word into the shifter. The data output does not change on that edge. Rising edge k (k = 1..24) then drives bit 24-k of the latched word, most significant bit first.
- R4: After the 24th bit, the data output is 0 on every further rising edge until the frame ends. No extra clock pulse shifts out any bit of a new word.
- R5: A frame ends once the serial clock shows no edge for TIMEOUT_CYC system cycles. The output then returns to 1. While the clock is still toggling, or before the timeout has elapsed, the frame stays active.
- R6: A frame that the master abandons partway is ended by the timeout. The next frame starts again at bit 23 of the load word, whether the clock was left high or low.
- R7: Back-to-back frames of an unchanged load word each return that same word (0x010101 never reads as 0x020202 or 0x040404).
- R8: A host write (ld_we_i high for one system cycle) while no frame is active sets the word sent by the next frame.
- R9: A host write during an active frame does not change the frame in progress. It is applied when the timeout ends the frame. Of several writes made during one frame, the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ssi_clk_i | input | 1 | Serial clock from the master, asynchronous, idles high |
| ssi_dat_o | output | 1 | Serial data to the master |
| ld_we_i | input | 1 | Host write strobe for the load word |
| ld_data_i | input | NBITS | Host load word |

## Verification
The bench sweeps a walking one through all 24 bit positions and also sends dense patterns. A design that shifted out on the wrong edge, or in the wrong order, would return a rotated or bit-reversed word. Repeated frames of 0x010101 that each end with the extra pulse expose a slave that treats the terminating pulse as the first bit of the next word: such a slave drifts left by one bit per frame. Abandoned frames, with the clock left high and with it left low, catch a shifter that is not reset by the timeout. Host writes made mid-frame, including two in one frame, catch a load path that corrupts the word in flight, drops the deferred value, or keeps the older of the two writes. The output is also checked at half the timeout, which catches a monoflop that fires early.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } ssi_edge_t;
endpackage

// File: rtl/ssi_edge_sync.sv
module ssi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               async_i,
  output ssi_pkg::ssi_edge_t edge_o
);
  localparam int PW = STAGES + 1;

  logic [PW-1:0] pipe_q;

  // idle-high line: reset to 1 so no spurious edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[PW-2:0], async_i};
  end

  assign edge_o.rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign edge_o.fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/ssi_monoflop.sv
module ssi_monoflop #(
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic any_edge_i,
  output logic expire_o
);
  localparam int TW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] cnt_q;

  assign expire_o = active_i & ~any_edge_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             cnt_q <= '0;
    else if (!active_i || any_edge_i || expire_o) cnt_q <= '0;
    else                                     cnt_q <= cnt_q + 1'b1;
  end

  AST_EXPIRE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o); // R5
endmodule

// File: rtl/ssi_load_reg.sv
module ssi_load_reg #(
  parameter int NBITS = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [NBITS-1:0] data_i,
  input  logic             active_i,
  input  logic             expire_i,
  output logic [NBITS-1:0] load_o
);
  logic [NBITS-1:0] load_q, pend_q;
  logic             pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q     <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else if (expire_i) begin
      // frame closes: newest value wins
      if (we_i)            load_q <= data_i;
      else if (pend_vld_q) load_q <= pend_q;
      pend_vld_q <= 1'b0;
    end else if (we_i) begin
      if (active_i) begin
        pend_q     <= data_i;
        pend_vld_q <= 1'b1;
      end else begin
        load_q <= data_i;
      end
    end
  end

  assign load_o = load_q;

  AST_HOLD_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !expire_i) |=> $stable(load_q)); // R9
endmodule

// File: rtl/ssi_shifter.sv
module ssi_shifter #(
  parameter int NBITS = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ssi_pkg::ssi_edge_t edge_i,
  input  logic               expire_i,
  input  logic [NBITS-1:0]   load_i,
  output logic               active_o,
  output logic               dat_o
);
  localparam int CW = $clog2(NBITS + 1);
  localparam logic [CW-1:0] LAST = CW'(NBITS);

  logic             active_q, dat_q;
  logic [CW-1:0]    cnt_q;
  logic [NBITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      dat_q    <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else if (expire_i) begin
      active_q <= 1'b0;
      dat_q    <= 1'b1;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (edge_i.fall) begin
        active_q <= 1'b1;
        sh_q     <= load_i;
        cnt_q    <= '0;
      end
    end else if (edge_i.rise) begin
      if (cnt_q < LAST) begin
        dat_q <= sh_q[NBITS-1];
        sh_q  <= {sh_q[NBITS-2:0], 1'b0};
        cnt_q <= cnt_q + 1'b1;
      end else begin
        dat_q <= 1'b0; // terminating pulse: never start a new word
      end
    end
  end

  assign active_o = active_q;
  assign dat_o    = dat_q;

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> dat_q); // R2
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R4
  AST_NO_SHIFT_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q == LAST && edge_i.rise && !expire_i) |=> !dat_q); // R4
  AST_EXPIRE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> (!active_q && dat_q)); // R5
endmodule

// File: rtl/ssi_slave.sv
module ssi_slave #(
  parameter int NBITS       = 24,
  parameter int TIMEOUT_CYC = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ssi_clk_i,
  output logic             ssi_dat_o,
  input  logic             ld_we_i,
  input  logic [NBITS-1:0] ld_data_i
);
  ssi_pkg::ssi_edge_t edge_s;
  logic               active_s, expire_s;
  logic [NBITS-1:0]   load_s;

  ssi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ssi_clk_i),
    .edge_o  (edge_s)
  );

  ssi_monoflop #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mono (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active_s),
    .any_edge_i (edge_s.rise | edge_s.fall),
    .expire_o   (expire_s)
  );

  ssi_load_reg #(.NBITS(NBITS)) u_load (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (ld_we_i),
    .data_i   (ld_data_i),
    .active_i (active_s),
    .expire_i (expire_s),
    .load_o   (load_s)
  );

  ssi_shifter #(.NBITS(NBITS)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (edge_s),
    .expire_i (expire_s),
    .load_i   (load_s),
    .active_o (active_s),
    .dat_o    (ssi_dat_o)
  );

  AST_OUT_HIGH_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_s) |-> ssi_dat_o); // R5
endmodule

// File: tb/tb_ssi_slave.sv
module tb_ssi_slave;
  localparam int NB = 24;
  localparam int TO = 40;
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ssi_clk = 1'b1;
  logic ssi_dat;
  logic ld_we = 1'b0;
  logic [NB-1:0] ld_data = '0;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  ssi_slave #(.NBITS(NB), .TIMEOUT_CYC(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ssi_clk_i(ssi_clk), .ssi_dat_o(ssi_dat),
    .ld_we_i(ld_we), .ld_data_i(ld_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [NB-1:0] v);
    @(negedge clk); ld_we = 1'b1; ld_data = v;
    @(negedge clk); ld_we = 1'b0;
  endtask

  task automatic pulse();
    ssi_clk = 1'b0; wait_cyc(H);
    ssi_clk = 1'b1; wait_cyc(H);
  endtask

  task automatic read_bits(input int n, output logic [NB-1:0] w);
    w = '0;
    for (int k = 0; k < n; k++) begin
      pulse();
      w = {w[NB-2:0], ssi_dat};
    end
  endtask

  // full frame incl. terminating pulse and timeout
  task automatic frame(input string req, input logic [NB-1:0] exp);
    logic [NB-1:0] w;
    read_bits(NB, w);
    chk(req, w, exp);
    pulse();
    chk("R4 low on terminating pulse", {23'd0, ssi_dat}, '0);
    wait_cyc(TO + 10);
    chk("R5 idle high after timeout", {23'd0, ssi_dat}, 24'd1);
  endtask

  initial begin
    logic [NB-1:0] a, b;
    wait_cyc(3);
    chk("R1 reset output", {23'd0, ssi_dat}, 24'd1);
    rst_n = 1'b1;
    wait_cyc(3);
    chk("R2 idle high", {23'd0, ssi_dat}, 24'd1);
    frame("R1 word zero after reset", 24'h000000);

    host_write(24'h010101);
    for (int i = 0; i < 3; i++) frame("R7 repeated aligned", 24'h010101);

    for (int i = 0; i < NB; i++) begin
      host_write(24'd1 << i);
      frame("R3 R8 walking one", 24'd1 << i);
    end
    host_write(24'hFFFFFF); frame("R3 all ones", 24'hFFFFFF);
    host_write(24'hA5C33C); frame("R3 mixed", 24'hA5C33C);

    // first falling edge alone leaves output high
    ssi_clk = 1'b0; wait_cyc(H);
    chk("R3 no change on latch edge", {23'd0, ssi_dat}, 24'd1);
    ssi_clk = 1'b1; wait_cyc(H);
    chk("R3 msb on first rise", {23'd0, ssi_dat}, 24'd1);
    wait_cyc(TO + 10);

    // extra pulses stay low; timeout not early
    host_write(24'h5A5A5A);
    read_bits(NB, a);
    chk("R3 word", a, 24'h5A5A5A);
    for (int i = 0; i < 3; i++) begin
      pulse();
      chk("R4 extra pulse low", {23'd0, ssi_dat}, '0);
    end
    wait_cyc(TO / 2);
    chk("R5 not ended early", {23'd0, ssi_dat}, '0);
    wait_cyc(TO);
    chk("R5 ended", {23'd0, ssi_dat}, 24'd1);
    frame("R7 aligned after extra pulses", 24'h5A5A5A);

    // abandoned with clock high
    host_write(24'hC0FFEE);
    read_bits(7, a);
    chk("R6 partial bits", a, {17'd0, 7'h60});
    wait_cyc(TO + 10);
    chk("R6 idle after abort", {23'd0, ssi_dat}, 24'd1);
    frame("R6 realigned after abort high", 24'hC0FFEE);

    // abandoned with clock low
    read_bits(5, a);
    ssi_clk = 1'b0; wait_cyc(TO + 10);
    ssi_clk = 1'b1; wait_cyc(H);
    chk("R6 idle rise ignored", {23'd0, ssi_dat}, 24'd1);
    frame("R6 realigned after abort low", 24'hC0FFEE);

    // deferred write
    host_write(24'h123456);
    read_bits(8, a);
    host_write(24'hABCDEF);
    read_bits(16, b);
    chk("R9 frame unaffected", {a[7:0], b[15:0]}, 24'h123456);
    pulse(); wait_cyc(TO + 10);
    frame("R9 deferred applied", 24'hABCDEF);

    // two writes in one frame, last wins
    read_bits(4, a);
    host_write(24'h111111);
    host_write(24'h777777);
    read_bits(20, b);
    chk("R9 frame unaffected 2", {a[3:0], b[19:0]}, 24'hABCDEF);
    pulse(); wait_cyc(TO + 10);
    frame("R9 last write wins", 24'h777777);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule